// File: doc/BRIEF.md
# Instruction Exception Entry Sequencer

This block starts exception processing for exceptions that instructions raise in a small 32-bit processor with 16-bit instructions. It watches the decode stage. A trap instruction, or an undefined opcode, is sorted into one of three causes: trap, undefined opcode in a delay slot (slot-illegal), or undefined opcode elsewhere (general illegal).

Once a cause is accepted, the block drives a word-wide memory port to build the exception frame. It stores the status word below the stack pointer and then stores the return address below that. It then loads the handler address from the vector table. Finally it hands the handler address and the lowered stack pointer to the core in a one-cycle load pulse. The redirect is not delayed, so no later instruction runs first.

The core holds off decode while `busy` is high. Decode requests that arrive while `busy` is high are dropped.

Top module: `exc_entry_seq`

## Requirements
- R1: An opcode whose top four bits are 0xF (0xF000 to 0xFFFF) is undefined. With `dec_in_slot` high it is classified slot-illegal and uses vector 6. With `dec_in_slot` low it is classified general illegal and uses vector 4.
- R2: An opcode whose upper byte is 0xC3 is a trap, and its lower byte is the vector number. A trap sitting in a delay slot is treated as slot-illegal (vector 6). Slot-illegal takes priority over general illegal, and general illegal takes priority over trap.
- R3: The first memory access is a write (`mem_we`=1) of `cur_sr` to address `cur_sp`-4.
- R4: The second access is a write of the return address to `cur_sp`-8. The return address is `cur_pc`+2 for a trap and `cur_pc` for both illegal causes.
- R5: The third access is a read (`mem_we`=0) at `vec_base` + 4 × vector number.
- R6: After the read completes, `pc_load` pulses high for exactly one cycle. During that cycle `new_pc` equals the word that was read and `new_sp` equals `cur_sp`-8.
- R7: Each access keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until the cycle in which `mem_ready` is high. Any number of wait cycles is accepted, including none.
- R8: `busy` rises in the cycle after an exception is accepted and stays high up to and including the `pc_load` cycle. `dec_valid` is ignored while `busy` is high.
- R9: An opcode that is neither a trap nor undefined starts nothing: `busy` and `mem_req` stay low.
- R10: After reset, `busy`, `mem_req` and `pc_load` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode stage presents an instruction |
| dec_opcode | input | 16 | Decoded instruction word |
| dec_in_slot | input | 1 | Instruction sits in a delay slot |
| cur_sr | input | 32 | Current status register |
| cur_pc | input | 32 | Address of the decoded instruction |
| cur_sp | input | 32 | Current stack pointer |
| vec_base | input | 32 | Vector table base address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Entry sequence in progress |
| pc_load | output | 1 | One-cycle strobe to load new PC and SP |
| new_pc | output | 32 | Handler start address |
| new_sp | output | 32 | Stack pointer after both pushes |

## Verification
An accepted exception raises `busy` one clock edge after `dec_valid` is sampled. The first request appears in that same cycle. Each access completes on the edge where `mem_ready` is high, and the next access starts right after it. `pc_load` follows one cycle after the vector read completes, and `busy` drops on the edge after `pc_load`.

The bench's memory responder raises `mem_ready` after a set number of waiting cycles. At that same falling edge it compares the held request against the expected queue. The load is compared at the falling edge where `pc_load` is high, and `busy` is checked one falling edge after the stimulus and again after the sequence ends.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int XLEN       = 32;
    localparam int OPW        = 16;
    localparam int VEC_W      = 8;
    localparam int WORD_BYTES = XLEN / 8;
    localparam int WORD_SHIFT = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_TRAP = 2'd1,
        CAUSE_SLOT = 2'd2,
        CAUSE_GEN  = 2'd3
    } exc_cause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_SR,
        ST_PUSH_PC,
        ST_FETCH_VEC,
        ST_LOAD
    } seq_state_e;

    typedef struct packed {
        logic [XLEN-1:0] sr;
        logic [XLEN-1:0] ret_pc;
        logic [XLEN-1:0] sp;
        logic [XLEN-1:0] vaddr;
        logic [XLEN-1:0] handler;
    } exc_ctx_t;

    function automatic logic [XLEN-1:0] vec_addr(input logic [XLEN-1:0] base,
                                                 input logic [VEC_W-1:0] num);
        return base + (XLEN'(num) << WORD_SHIFT);
    endfunction

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_seq_pkg::*;
#(
    parameter logic [7:0]       TRAP_OP  = 8'hC3,
    parameter logic [VEC_W-1:0] VEC_GEN  = 8'd4,
    parameter logic [VEC_W-1:0] VEC_SLOT = 8'd6
) (
    input  logic [OPW-1:0]   opcode,
    input  logic             in_slot,
    output exc_cause_e       cause,
    output logic [VEC_W-1:0] vec
);
    logic undef_op;
    logic trap_op;

    always_comb begin
        undef_op = (opcode[OPW-1 -: 4] == 4'hF);
        trap_op  = (opcode[OPW-1 -: 8] == TRAP_OP);
        if (in_slot && (undef_op || trap_op)) begin
            cause = CAUSE_SLOT;
            vec   = VEC_SLOT;
        end else if (undef_op) begin
            cause = CAUSE_GEN;
            vec   = VEC_GEN;
        end else if (trap_op) begin
            cause = CAUSE_TRAP;
            vec   = opcode[VEC_W-1:0];
        end else begin
            cause = CAUSE_NONE;
            vec   = '0;
        end
    end

endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
    import exc_seq_pkg::*;
#(
    parameter int INSN_BYTES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  exc_cause_e       cause,
    input  logic [VEC_W-1:0] vec,
    input  logic [XLEN-1:0]  sr_in,
    input  logic [XLEN-1:0]  pc_in,
    input  logic [XLEN-1:0]  sp_in,
    input  logic [XLEN-1:0]  vbase,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic             mem_ready,
    output logic             busy,
    output logic             pc_load,
    output logic [XLEN-1:0]  new_pc,
    output logic [XLEN-1:0]  new_sp
);
    seq_state_e state;
    exc_ctx_t   ctx;
    logic [XLEN-1:0] push_addr;

    assign push_addr = ctx.sp - XLEN'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ctx   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    ctx.sr      <= sr_in;
                    ctx.ret_pc  <= (cause == CAUSE_TRAP) ? pc_in + XLEN'(INSN_BYTES) : pc_in;
                    ctx.sp      <= sp_in;
                    ctx.vaddr   <= vec_addr(vbase, vec);
                    ctx.handler <= '0;
                    state       <= ST_PUSH_SR;
                end
                ST_PUSH_SR: if (mem_ready) begin
                    ctx.sp <= push_addr;
                    state  <= ST_PUSH_PC;
                end
                ST_PUSH_PC: if (mem_ready) begin
                    ctx.sp <= push_addr;
                    state  <= ST_FETCH_VEC;
                end
                ST_FETCH_VEC: if (mem_ready) begin
                    ctx.handler <= mem_rdata;
                    state       <= ST_LOAD;
                end
                ST_LOAD: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_PUSH_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = ctx.sr;
            end
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = ctx.ret_pc;
            end
            ST_FETCH_VEC: begin
                mem_req  = 1'b1;
                mem_addr = ctx.vaddr;
            end
            default: ;
        endcase
    end

    assign busy    = (state != ST_IDLE);
    assign pc_load = (state == ST_LOAD);
    assign new_pc  = ctx.handler;
    assign new_sp  = ctx.sp;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req && !pc_load); // R8
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy); // R8
    AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(pc_load) |-> $past(mem_req && !mem_we && mem_ready)); // R6
    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !pc_load && !busy); // R6

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter logic [7:0]       TRAP_OP    = 8'hC3,
    parameter logic [VEC_W-1:0] VEC_GEN    = 8'd4,
    parameter logic [VEC_W-1:0] VEC_SLOT   = 8'd6,
    parameter int               INSN_BYTES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dec_valid,
    input  logic [15:0]     dec_opcode,
    input  logic            dec_in_slot,
    input  logic [31:0]     cur_sr,
    input  logic [31:0]     cur_pc,
    input  logic [31:0]     cur_sp,
    input  logic [31:0]     vec_base,
    output logic            mem_req,
    output logic            mem_we,
    output logic [31:0]     mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_ready,
    output logic            busy,
    output logic            pc_load,
    output logic [31:0]     new_pc,
    output logic [31:0]     new_sp
);
    exc_cause_e       cause;
    logic [VEC_W-1:0] vec;
    logic             start;

    exc_classify #(
        .TRAP_OP (TRAP_OP),
        .VEC_GEN (VEC_GEN),
        .VEC_SLOT(VEC_SLOT)
    ) u_classify (
        .opcode (dec_opcode),
        .in_slot(dec_in_slot),
        .cause  (cause),
        .vec    (vec)
    );

    assign start = dec_valid && (cause != CAUSE_NONE);

    exc_sequencer #(
        .INSN_BYTES(INSN_BYTES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cause    (cause),
        .vec      (vec),
        .sr_in    (cur_sr),
        .pc_in    (cur_pc),
        .sp_in    (cur_sp),
        .vbase    (vec_base),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .mem_ready(mem_ready),
        .busy     (busy),
        .pc_load  (pc_load),
        .new_pc   (new_pc),
        .new_sp   (new_sp)
    );

    AST_SLOT_ONLY_IN_DS: assert property (@(posedge clk) disable iff (rst)
        dec_valid && cause == CAUSE_SLOT |-> dec_in_slot); // R1
    AST_NONE_NO_START: assert property (@(posedge clk) disable iff (rst)
        dec_valid && !busy && cause == CAUSE_NONE |=> !busy); // R9

endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dec_valid = 1'b0;
    logic [15:0] dec_opcode = '0;
    logic        dec_in_slot = 1'b0;
    logic [31:0] cur_sr = '0, cur_pc = '0, cur_sp = '0, vec_base = '0;
    logic        mem_req, mem_we, busy, pc_load;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, new_pc, new_sp;
    logic        mem_ready = 1'b0;

    int total = 0;
    int bad   = 0;
    int wait_cfg = 0;
    int wcnt = 0;
    int cycles = 0;

    int          q_kind[$];
    logic [31:0] q_a[$];
    logic [31:0] q_d[$];
    string       q_req[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = 32'h4000_0000 ^ mem_addr;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_opcode(dec_opcode),
        .dec_in_slot(dec_in_slot), .cur_sr(cur_sr), .cur_pc(cur_pc), .cur_sp(cur_sp),
        .vec_base(vec_base), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .busy(busy), .pc_load(pc_load), .new_pc(new_pc), .new_sp(new_sp)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push_exp(input int kind, input logic [31:0] a, input logic [31:0] d,
                            input string req);
        q_kind.push_back(kind); q_a.push_back(a); q_d.push_back(d); q_req.push_back(req);
    endtask

    // Memory responder and monitor: the transaction is recorded when ready is raised,
    // since it completes on the following rising edge.
    always @(negedge clk) begin
        cycles++;
        if (pc_load) begin
            if (q_kind.size() == 0) check(0, "R6", "unexpected load", new_pc, 32'h0);
            else begin
                check(q_kind[0] == 2, q_req[0], "load kind", 32'(2), 32'(q_kind[0]));
                check(new_pc == q_a[0], "R6", "new_pc", new_pc, q_a[0]);
                check(new_sp == q_d[0], "R6", "new_sp", new_sp, q_d[0]);
                void'(q_kind.pop_front()); void'(q_a.pop_front());
                void'(q_d.pop_front()); void'(q_req.pop_front());
            end
        end
        if (mem_ready) wcnt = 0;
        if (mem_req && !rst) begin
            if (wcnt >= wait_cfg) begin
                mem_ready = 1'b1;
                wcnt = 0;
                if (q_kind.size() == 0) check(0, "R8", "unexpected access", mem_addr, 32'h0);
                else begin
                    check(32'(mem_we ? 0 : 1) == 32'(q_kind[0]), q_req[0], "access type",
                          32'(mem_we), 32'(q_kind[0] == 0));
                    check(mem_addr == q_a[0], q_req[0], "address", mem_addr, q_a[0]);
                    if (q_kind[0] == 0)
                        check(mem_wdata == q_d[0], q_req[0], "write data", mem_wdata, q_d[0]);
                    void'(q_kind.pop_front()); void'(q_a.pop_front());
                    void'(q_d.pop_front()); void'(q_req.pop_front());
                end
            end else begin
                mem_ready = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ready = 1'b0;
            wcnt = 0;
        end
    end

    // Driver: computes the expected frame from the requirements and drives decode.
    task automatic run_exc(input logic [15:0] op, input bit slot, input logic [31:0] sr,
                           input logic [31:0] pc, input logic [31:0] sp,
                           input logic [31:0] vb, input int waits, input bit poke);
        logic [7:0]  vec;
        logic [31:0] ret;
        bit undef, trap;
        undef = (op[15:12] == 4'hF);
        trap  = (op[15:8] == 8'hC3);
        if (slot && (undef || trap)) begin vec = 8'd6; ret = pc; end       // R1 R2
        else if (undef)              begin vec = 8'd4; ret = pc; end       // R1
        else                         begin vec = op[7:0]; ret = pc + 2; end // R2
        wait_cfg = waits;
        push_exp(0, sp - 4, sr, "R3");
        push_exp(0, sp - 8, ret, "R4");
        push_exp(1, vb + {22'd0, vec, 2'b00}, 32'h0, "R5");
        push_exp(2, 32'h4000_0000 ^ (vb + {22'd0, vec, 2'b00}), sp - 8, "R6");
        @(negedge clk);
        dec_opcode = op; dec_in_slot = slot; cur_sr = sr; cur_pc = pc;
        cur_sp = sp; vec_base = vb; dec_valid = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R8", "busy after accept", 32'(busy), 32'h1);
        if (poke) begin
            dec_opcode = 16'hC355; dec_in_slot = 1'b0; cur_sp = 32'h0000_9000;
            repeat (3) @(negedge clk);
        end
        dec_valid = 1'b0;
        while (q_kind.size() != 0) @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R8", "busy after load", 32'(busy), 32'h0);
        check(mem_req == 1'b0, "R8", "no extra request", 32'(mem_req), 32'h0);
    endtask

    task automatic run_none(input logic [15:0] op, input bit slot);
        @(negedge clk);
        dec_opcode = op; dec_in_slot = slot; dec_valid = 1'b1;
        @(negedge clk);
        dec_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(busy == 1'b0 && mem_req == 1'b0, "R9", "defined opcode ignored",
                  {30'd0, busy, mem_req}, 32'h0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(busy == 1'b0, "R10", "busy at reset", 32'(busy), 32'h0);
        check(mem_req == 1'b0, "R10", "mem_req at reset", 32'(mem_req), 32'h0);
        check(pc_load == 1'b0, "R10", "pc_load at reset", 32'(pc_load), 32'h0);

        run_exc(16'hC321, 1'b0, 32'h0000_00F0, 32'h0000_1000, 32'h0000_8000, 32'h0000_0400, 0, 0); // R2
        run_exc(16'hF123, 1'b0, 32'h1234_5678, 32'h0000_2002, 32'h0001_0000, 32'h0000_0000, 2, 0); // R1 R7
        run_exc(16'hFFFF, 1'b1, 32'hAAAA_5555, 32'h0000_3004, 32'h0002_0000, 32'h0000_1000, 1, 0); // R1
        run_exc(16'hC310, 1'b1, 32'h0000_0001, 32'h0000_4000, 32'h0003_0000, 32'h0000_2000, 0, 0); // R2 priority
        run_exc(16'hF000, 1'b0, 32'h8000_0000, 32'h0000_5000, 32'h0004_0000, 32'h0000_3000, 3, 0); // R1 boundary
        run_none(16'hEFFF, 1'b0);                                                                  // R9
        run_none(16'hC200, 1'b1);                                                                  // R9
        run_exc(16'hC3FF, 1'b0, 32'h0F0F_0F0F, 32'hFFFF_FFFE, 32'h0000_0004, 32'h0000_8000, 3, 1); // R8 R7 wrap
        run_exc(16'hC300, 1'b0, 32'h0000_0002, 32'h0000_6000, 32'h0005_0000, 32'h0000_0100, 0, 1); // R8

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles >= WATCHDOG);
        total++;
        bad++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule